// File: doc/BRIEF.md
# Compressed voxel block interpolator

This block turns one compressed 32-bit voxel-block word into one 8-bit trilinearly interpolated sample. A block of twelve voxels is stored as only two grayvalues: a base value and the difference up to the second value. Each voxel position has one decision bit that chooses between them. Because a cell holds just two distinct values, interpolation needs no blending of eight voxels. A precomputed compound weight is read from an external table and applied in one multiply and one add.

The table address is formed from an 8-bit window of the decision bits and three 4-bit fractional offsets. The low bit of the ray point's x coordinate picks the window. The block issues the read on a synchronous table port and gets the weight back one cycle later. It then computes the sample and delivers it, with the block's material tag, on a valid/ready output.

A block whose base value is zero is empty. Its other bits carry other information, so the block raises a flag and does not produce a grayvalue for it. Accepted elements leave in order, and the pipeline stalls as a whole under backpressure.

Top module: `voxblk_interp`

## Requirements
- R1: Word layout: decision bits D11..D0 sit in bits 31..20 (D0 at bit 20), the material tag in bits 19..16, the base value in bits 15..8 and the difference in bits 7..0. In every cycle in which an element is accepted, the block drives `tbl_addr` = {window[7:0], off_y, off_z, off_x} (window in bits 19..12, off_x in bits 3..0).
- R2: The window is D7..D0 (word bits 27..20) when `x_lsb` is 0, and D11..D4 (word bits 31..24) when `x_lsb` is 1.
- R3: For a non-empty element, `out_sample` = base + ((w * diff) >> 8), where w is the 8-bit table word returned for that element's address.
- R4: When that sum exceeds 255, `out_sample` is 255.
- R5: When base is 0, `out_empty` is 1 and `out_sample` and `out_mat` are both 0. The other fields have no effect. For non-empty elements `out_empty` is 0.
- R6: For non-empty elements, `out_mat` equals the material tag of the same element.
- R7: With `out_ready` held high, an element accepted at a clock edge appears on the outputs (`out_valid` = 1) right after the second following edge. Elements can be accepted on consecutive cycles and leave in order.
- R8: While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady. With all three stages full, `in_ready` is 0. No element is lost or duplicated.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: `tbl_en` is 1 exactly in the cycles where `in_valid` and `in_ready` are both 1. The table must return its word on `tbl_data` after the next edge and hold it while `tbl_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can accept an element |
| in_word | input | 32 | Compressed block word |
| off_x | input | 4 | Fractional x offset |
| off_y | input | 4 | Fractional y offset |
| off_z | input | 4 | Fractional z offset |
| x_lsb | input | 1 | Low bit of the ray point x coordinate |
| tbl_en | output | 1 | Weight table read strobe |
| tbl_addr | output | 20 | Weight table address |
| tbl_data | input | 8 | Weight returned by the table one edge after the strobe |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | 8 | Interpolated sample |
| out_mat | output | 4 | Material tag of the element |
| out_empty | output | 1 | Element was an empty block |

## Verification
The hardest case to reach is a full pipeline under backpressure. In that state the table has already answered for the element in the first stage, and it must keep that word while reads are held off. The stimulus holds `out_ready` low while three elements go in back to back, so every stage is full and `in_ready` drops. It then checks that the outputs stay frozen and the drained results still match. A second phase toggles `out_ready` at random against a stream of random words. A table model that keeps its output while not strobed checks that the weight in the first stage is not lost. Directed words cover saturation and the two decision windows, and empty blocks with non-zero tag and difference fields check that those fields are ignored.

// File: rtl/voxblk_interp.sv
module voxblk_interp #(
  parameter int GW = 8,
  parameter int FW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_word,
  input  logic [FW-1:0]        off_x,
  input  logic [FW-1:0]        off_y,
  input  logic [FW-1:0]        off_z,
  input  logic                 x_lsb,
  output logic                 tbl_en,
  output logic [GW+3*FW-1:0]   tbl_addr,
  input  logic [GW-1:0]        tbl_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [GW-1:0]        out_sample,
  output logic [3:0]           out_mat,
  output logic                 out_empty
);
  localparam int DLO = 20;
  localparam int MLO = 16;
  localparam logic [GW:0] SMAX = {1'b0, {GW{1'b1}}};

  logic          adv;
  logic          s1_v, s2_v;
  logic [GW-1:0] s1_base, s1_diff, s2_base, s2_scaled;
  logic [3:0]    s1_mat, s2_mat;
  logic [GW-1:0] window;
  logic [2*GW-1:0] prod;
  logic [GW:0]   sum;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign tbl_en   = in_valid && adv;
  assign window   = x_lsb ? in_word[DLO+11 -: 8] : in_word[DLO+7 -: 8];
  assign tbl_addr = {window, off_y, off_z, off_x};
  assign prod     = tbl_data * s1_diff;
  assign sum      = {1'b0, s2_base} + {1'b0, s2_scaled};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_v      <= tbl_en;
      s2_v      <= s1_v;
      out_valid <= s2_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_base   <= in_word[15:8];
      s1_diff   <= in_word[7:0];
      s1_mat    <= in_word[MLO+3:MLO];
      s2_base   <= s1_base;
      s2_scaled <= prod[2*GW-1:GW];
      s2_mat    <= s1_mat;
      out_empty <= (s2_base == '0);
      out_mat   <= (s2_base == '0) ? 4'd0 : s2_mat;
      out_sample <= (s2_base == '0) ? '0 : (sum > SMAX ? {GW{1'b1}} : sum[GW-1:0]);
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_sample) && $stable(out_mat) && $stable(out_empty));
  // R5
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_empty |-> out_sample == '0 && out_mat == 4'd0);
  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R10
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_en |-> in_valid && in_ready);
endmodule

// File: tb/sim_voxblk_interp.sv
module sim_voxblk_interp;
  localparam int TCK = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, x_lsb = 0, tbl_en, out_valid, out_ready = 1, out_empty;
  logic [31:0] in_word = 0;
  logic [3:0]  off_x = 0, off_y = 0, off_z = 0, out_mat;
  logic [19:0] tbl_addr;
  logic [7:0]  tbl_data, out_sample;

  int total = 0, bad = 0, cyc = 0;
  bit lat_chk = 1, rnd_rdy = 0, done = 0;
  logic [12:0] exp_q[$];
  int acc_q[$];

  always #(TCK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tbl_f(input logic [19:0] a);
    return a[7:0] ^ a[19:12];
  endfunction

  always_ff @(posedge clk) if (tbl_en) tbl_data <= tbl_f(tbl_addr);

  voxblk_interp u0 (.clk, .rst_n, .in_valid, .in_ready, .in_word, .off_x, .off_y, .off_z,
    .x_lsb, .tbl_en, .tbl_addr, .tbl_data, .out_valid, .out_ready, .out_sample, .out_mat,
    .out_empty);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [3:0] fx, fy, fz, input logic xs);
    logic [7:0] win, wt, base, diff;
    logic [19:0] ea;
    logic [8:0] s;
    win = xs ? w[31:24] : w[27:20];
    ea = {win, fy, fz, fx};
    wt = tbl_f(ea);
    base = w[15:8]; diff = w[7:0];
    s = {1'b0, base} + {1'b0, 8'((16'(wt) * 16'(diff)) >> 8)};
    @(negedge clk);
    in_valid = 1; in_word = w; off_x = fx; off_y = fy; off_z = fz; x_lsb = xs;
    forever begin
      #1;
      chk(tbl_en == in_ready, "R10 strobe", tbl_en, in_ready);
      if (in_ready) begin
        chk(tbl_addr == ea, "R1/R2 address", tbl_addr, ea);
        if (base == 0) exp_q.push_back(13'h1000);
        else exp_q.push_back({1'b0, w[19:16], (s > 9'd255) ? 8'hFF : s[7:0]});
        acc_q.push_back(cyc + 1);
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    logic [12:0] e;
    int a;
    forever begin
      @(negedge clk); #2;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R8 extra output", 1, 0);
        else begin
          e = exp_q.pop_front(); a = acc_q.pop_front();
          chk({out_empty, out_mat, out_sample} == e, "R3/R4/R5/R6 result",
              {out_empty, out_mat, out_sample}, e);
          if (lat_chk) chk(cyc - a == 2, "R7 latency", cyc - a, 2);
        end
      end
    end
  end

  always @(negedge clk) if (rnd_rdy) out_ready <= $urandom_range(0, 2) != 0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin : stim
    logic [7:0] so; logic [12:0] sk;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R9 reset valid", out_valid, 0);
    chk(in_ready == 1, "R9 reset ready", in_ready, 1);
    rst_n = 1;
    // R2 window choice, R3 arithmetic
    send(32'h5A3_7_40_90, 4'h3, 4'h9, 4'hC, 0);
    send(32'h5A3_7_40_90, 4'h3, 4'h9, 4'hC, 1);
    // R4 saturation: window FF, offsets 0 give weight FF
    send(32'hFF0_2_FF_FF, 4'h0, 4'h0, 4'h0, 1);
    chk(exp_q[exp_q.size()-1][7:0] == 8'hFF, "R4 sat expectation", exp_q[exp_q.size()-1][7:0], 8'hFF);
    // R5 empty with non-zero tag and difference
    send(32'hABC_D_00_77, 4'h1, 4'h2, 4'h3, 0);
    // R6 tag passthrough, small base
    send(32'h123_9_01_00, 4'hF, 4'hF, 4'hF, 1);
    idle(6);
    // R8 full pipeline stall
    lat_chk = 0;
    @(negedge clk); out_ready = 0;
    send(32'h777_1_20_80, 4'h4, 4'h5, 4'h6, 0);
    send(32'h888_2_30_F0, 4'h7, 4'h8, 4'h9, 1);
    send(32'h999_3_00_11, 4'hA, 4'hB, 4'hC, 0);
    @(negedge clk); in_valid = 0;
    #2;
    so = out_sample; sk = {out_empty, out_mat, out_sample};
    repeat (4) @(negedge clk);
    #2;
    chk(in_ready == 0, "R8 full stall ready", in_ready, 0);
    chk(out_valid == 1, "R8 valid held", out_valid, 1);
    chk({out_empty, out_mat, out_sample} == sk, "R8 data held", {out_empty, out_mat, out_sample}, sk);
    @(negedge clk); out_ready = 1;
    idle(6);
    chk(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
    // random traffic with random backpressure
    rnd_rdy = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 7 == 0) w[15:8] = 0;
      send(w, 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom));
    end
    @(negedge clk); in_valid = 0;
    rnd_rdy = 0;
    @(negedge clk); out_ready = 1;
    idle(8);
    chk(exp_q.size() == 0, "R8 all delivered", exp_q.size(), 0);
    chk(out_valid == 0, "R7 pipeline empty", out_valid, 0);
    finish_run();
  end
endmodule